// File: doc/BRIEF.md
# Multi-Lane Release-Delay Deskew Buffer

This block is a receive-side elastic store for a group of serial lanes, four by default. The lanes reach the receiver with different delays. Each lane begins filling its own small buffer on the data word that carries its extended-multiblock start marker. Nothing is read out until every enabled lane has started and the shared local multiblock counter then equals a release point. At that moment all lanes begin draining together, one word per cycle, so the lanes leave the block aligned with each other.

The release point comes from one of two places, chosen at run time:
- **Manual:** it is taken from a register input.
- **Automatic:** it is computed as the latest lane-arrival timestamp plus a fixed margin of four, wrapped to the counter period.

The usable buffer depth can be changed at run time through a depth-minus-one input. It resets to the full storage depth.

If a lane is asked to hold more words than the configured depth before release, a sticky error is raised and the aligned-valid output stays low. A relink pulse clears every lane and the release and error state, and waits for fresh markers. The configured depth is kept across a relink.

Top module: `lane_deskew_buffer`

## Requirements
- R1: The effective depth is `depth_m1 + 1`, loaded on a `depth_wr` cycle. A started lane that already holds that many words before release raises the overflow error instead of storing the word. With depth 8 and a 7-cycle lead, nothing overflows. With depth 7, it overflows.
- R2: After reset both outputs are low and the depth is 32. A lane may therefore buffer 32 words before release, but not 33.
- R3: In manual mode (`auto_release` = 0), release happens at the first clock edge where the block is armed and `mb_count` equals `release_at`. From the next cycle on, `aligned_valid` is 1.
- R4: In automatic mode, the release point is `(last_arrival + 4) mod 64*E`. A last arrival of 6 releases at count 10. A last arrival of 62 releases at count 2.
- R5: A lane starts storing on the first cycle that its bit of `lane_marker` is 1 after reset or relink, and stores that word first. Earlier words are discarded.
- R6: The overflow error is sticky until reset or relink. While it is set, `aligned_valid` stays 0, even after the release point passes.
- R7: After release, lane i appears on `aligned_data[8i+7:8i]`. Every lane shows its marker word in the same first valid cycle, and then advances by one stored word each cycle.
- R8: Release is armed only once every enabled lane has started. A counter match before that is ignored.
- R9: A lane whose `lane_enable` bit is 0 never starts and does not hold back arming. Its output slice reads 0.
- R10: A relink cycle clears all lanes, the release state and the overflow error. In the following cycle both `aligned_valid` and `overflow_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| relink | input | 1 | Restart pulse: clears lanes, release and error state |
| lane_enable | input | LANES | Per-lane enable |
| lane_marker | input | LANES | Per-lane extended-multiblock start flag, valid with the word |
| lane_data | input | LANES*DATA_W | Per-lane input word, one per cycle |
| mb_count | input | CNT_W | Shared local multiblock counter, 0 to 64*E-1 |
| release_at | input | CNT_W | Manual release point |
| auto_release | input | 1 | 1 selects the release point from the arrival timestamp |
| last_arrival | input | CNT_W | Counter value at which the last lane arrived |
| depth_wr | input | 1 | Load `depth_m1` into the depth register |
| depth_m1 | input | DCFG_W | Buffer depth minus one |
| aligned_valid | output | 1 | Aligned data valid |
| aligned_data | output | LANES*DATA_W | Aligned lane words |
| overflow_err | output | 1 | Sticky overflow error |

## Verification
The hardest situation to reach from the ports is a counter match that occurs while one lane is still missing. The only such match that keeps the other lanes under the depth limit is one where the shared counter comes round to the release point again soon after. With a counter that only moves forward, that takes a full period, and the buffers overflow long before. The bench therefore drives the shared counter as a free input. After the late lane's marker, it jumps the counter back a few counts so that the release point recurs while the early lanes still have room. The bench then confirms that release happens on that second match and not on the first. The exact depth boundaries are reached by placing the markers so that the earliest lane leads the release point by exactly the configured depth, and by one word more.

// File: rtl/lane_deskew_pkg.sv
`timescale 1ns/1ps
package lane_deskew_pkg;

    // Release state shared by the controller
    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_DRAIN  = 1'b1
    } drain_phase_e;

endpackage

// File: rtl/deskew_lane_store.sv
`timescale 1ns/1ps
module deskew_lane_store #(
    parameter  int DATA_W    = 8,
    parameter  int BUF_DEPTH = 32,
    localparam int PTR_W     = $clog2(BUF_DEPTH),
    localparam int FILL_W    = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              relink_i,
    input  logic              enable_i,
    input  logic              marker_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [FILL_W-1:0] depth_i,
    input  logic              drain_i,
    output logic              started_o,
    output logic              overflow_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              started;
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [FILL_W-1:0] fill;
    } lane_state_t;

    lane_state_t       state_d, state_q;
    logic              wr_en, rd_en, ovf_d;
    logic [DATA_W-1:0] store_q [BUF_DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        ovf_d   = 1'b0;
        if (relink_i || !enable_i) begin
            state_d = '0;
        end else begin
            rd_en = drain_i && state_q.started;
            if (state_q.started) begin
                if (!drain_i && (state_q.fill >= depth_i)) begin
                    ovf_d = 1'b1;
                end else begin
                    wr_en = 1'b1;
                end
            end else if (marker_i) begin
                state_d.started = 1'b1;
                wr_en           = 1'b1;
            end
            if (wr_en) begin
                state_d.wr_ptr = bump(state_q.wr_ptr);
            end
            if (rd_en) begin
                state_d.rd_ptr = bump(state_q.rd_ptr);
            end
            state_d.fill = state_q.fill + FILL_W'(wr_en) - FILL_W'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[state_q.wr_ptr] <= data_i;
        end
    end

    assign started_o  = state_q.started;
    assign overflow_o = ovf_d;
    assign data_o     = enable_i ? store_q[state_q.rd_ptr] : '0;

    // R5
    marker_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.started) |-> $past(marker_i && enable_i && !relink_i));

    // R1
    depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!relink_i && enable_i && state_q.started && !drain_i && (state_q.fill >= depth_i))
        |=> (state_q.fill == $past(state_q.fill)));

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && enable_i && state_q.started && !relink_i)
        |=> (state_q.rd_ptr == bump($past(state_q.rd_ptr))));

endmodule

// File: rtl/deskew_release_ctrl.sv
`timescale 1ns/1ps
module deskew_release_ctrl
    import lane_deskew_pkg::*;
#(
    parameter  int LANES     = 4,
    parameter  int CNT_W     = 6,
    parameter  int PERIOD    = 64,
    parameter  int MARGIN    = 4,
    parameter  int BUF_DEPTH = 32,
    localparam int DCFG_W    = $clog2(BUF_DEPTH),
    localparam int FILL_W    = DCFG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              relink_i,
    input  logic [LANES-1:0]  enable_i,
    input  logic [LANES-1:0]  started_i,
    input  logic [LANES-1:0]  lane_ovf_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  rbd_i,
    input  logic              auto_i,
    input  logic [CNT_W-1:0]  last_arr_i,
    input  logic              depth_load_i,
    input  logic [DCFG_W-1:0] depth_val_i,
    output logic              drain_o,
    output logic              overflow_o,
    output logic [FILL_W-1:0] depth_o
);

    typedef struct packed {
        drain_phase_e      phase;
        logic              overflow;
        logic [DCFG_W-1:0] depth_m1;
    } ctrl_state_t;

    ctrl_state_t      state_d, state_q;
    logic             all_started;
    logic [CNT_W:0]   sum_ext;
    logic [CNT_W-1:0] target;

    always_comb begin
        all_started = (&(started_i | ~enable_i)) && (|enable_i);
        sum_ext     = {1'b0, last_arr_i} + (CNT_W+1)'(MARGIN);
        if (sum_ext >= (CNT_W+1)'(PERIOD)) begin
            sum_ext = sum_ext - (CNT_W+1)'(PERIOD);
        end
        target = auto_i ? sum_ext[CNT_W-1:0] : rbd_i;

        state_d = state_q;
        if (depth_load_i) begin
            state_d.depth_m1 = depth_val_i;
        end
        if (relink_i) begin
            state_d.phase    = PH_GATHER;
            state_d.overflow = 1'b0;
        end else begin
            if (|lane_ovf_i) begin
                state_d.overflow = 1'b1;
            end
            if ((state_q.phase == PH_GATHER) && all_started && (count_i == target)) begin
                state_d.phase = PH_DRAIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.phase    <= PH_GATHER;
            state_q.overflow <= 1'b0;
            state_q.depth_m1 <= DCFG_W'(BUF_DEPTH - 1);
        end else begin
            state_q <= state_d;
        end
    end

    assign drain_o    = (state_q.phase == PH_DRAIN);
    assign overflow_o = state_q.overflow;
    assign depth_o    = FILL_W'(state_q.depth_m1) + FILL_W'(1);

    // R3
    manual_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drain_o) && $past(!auto_i)) |-> ($past(count_i) == $past(rbd_i)));

    // R4
    auto_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drain_o) && $past(auto_i))
        |-> (int'($past(count_i)) == ((int'($past(last_arr_i)) + MARGIN) % PERIOD)));

    // R8
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_o) |-> $past(&(started_i | ~enable_i)));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !relink_i) |=> overflow_o);

    // R10
    relink_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        relink_i |=> (!drain_o && !overflow_o));

endmodule

// File: rtl/lane_deskew_buffer.sv
`timescale 1ns/1ps
module lane_deskew_buffer #(
    parameter  int LANES     = 4,
    parameter  int DATA_W    = 8,
    parameter  int BUF_DEPTH = 32,
    parameter  int EMB_E     = 1,
    parameter  int MARGIN    = 4,
    localparam int PERIOD    = 64 * EMB_E,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int DCFG_W    = $clog2(BUF_DEPTH),
    localparam int FILL_W    = DCFG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    relink,
    input  logic [LANES-1:0]        lane_enable,
    input  logic [LANES-1:0]        lane_marker,
    input  logic [LANES*DATA_W-1:0] lane_data,
    input  logic [CNT_W-1:0]        mb_count,
    input  logic [CNT_W-1:0]        release_at,
    input  logic                    auto_release,
    input  logic [CNT_W-1:0]        last_arrival,
    input  logic                    depth_wr,
    input  logic [DCFG_W-1:0]       depth_m1,
    output logic                    aligned_valid,
    output logic [LANES*DATA_W-1:0] aligned_data,
    output logic                    overflow_err
);

    logic [LANES-1:0]  started_w;
    logic [LANES-1:0]  lane_ovf_w;
    logic              drain_w;
    logic [FILL_W-1:0] depth_w;

    deskew_release_ctrl #(
        .LANES    (LANES),
        .CNT_W    (CNT_W),
        .PERIOD   (PERIOD),
        .MARGIN   (MARGIN),
        .BUF_DEPTH(BUF_DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .relink_i    (relink),
        .enable_i    (lane_enable),
        .started_i   (started_w),
        .lane_ovf_i  (lane_ovf_w),
        .count_i     (mb_count),
        .rbd_i       (release_at),
        .auto_i      (auto_release),
        .last_arr_i  (last_arrival),
        .depth_load_i(depth_wr),
        .depth_val_i (depth_m1),
        .drain_o     (drain_w),
        .overflow_o  (overflow_err),
        .depth_o     (depth_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        deskew_lane_store #(
            .DATA_W   (DATA_W),
            .BUF_DEPTH(BUF_DEPTH)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .relink_i  (relink),
            .enable_i  (lane_enable[g]),
            .marker_i  (lane_marker[g]),
            .data_i    (lane_data[g*DATA_W +: DATA_W]),
            .depth_i   (depth_w),
            .drain_i   (drain_w),
            .started_o (started_w[g]),
            .overflow_o(lane_ovf_w[g]),
            .data_o    (aligned_data[g*DATA_W +: DATA_W])
        );
    end

    assign aligned_valid = drain_w && !overflow_err;

    // R6
    valid_after_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow_err) && overflow_err) |-> !aligned_valid);

endmodule

// File: tb/test_lane_deskew_buffer.sv
`timescale 1ns/1ps
module test_lane_deskew_buffer;

    localparam int LN  = 4;
    localparam int DW  = 8;
    localparam int PER = 64;
    localparam int CW  = 6;
    localparam int DCW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             relink = 1'b0;
    logic [LN-1:0]    lane_enable = '1;
    logic [LN-1:0]    lane_marker = '0;
    logic [LN*DW-1:0] lane_data = '0;
    logic [CW-1:0]    mb_count = '0;
    logic [CW-1:0]    release_at = '0;
    logic             auto_release = 1'b0;
    logic [CW-1:0]    last_arrival = '0;
    logic             depth_wr = 1'b0;
    logic [DCW-1:0]   depth_m1 = '0;
    logic             aligned_valid;
    logic [LN*DW-1:0] aligned_data;
    logic             overflow_err;

    lane_deskew_buffer i_lane_deskew_buffer (
        .clk(clk), .rst_n(rst_n), .relink(relink), .lane_enable(lane_enable),
        .lane_marker(lane_marker), .lane_data(lane_data), .mb_count(mb_count),
        .release_at(release_at), .auto_release(auto_release), .last_arrival(last_arrival),
        .depth_wr(depth_wr), .depth_m1(depth_m1), .aligned_valid(aligned_valid),
        .aligned_data(aligned_data), .overflow_err(overflow_err)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R2";

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: one queue per lane
    logic [DW-1:0] mq [LN][$];
    bit            m_started [LN];
    bit            m_rel, m_ovf;
    int            m_depth;

    always @(posedge clk) begin : ref_model
        bit all_in;
        bit any_en;
        bit was_rel;
        int tgt;
        if (!rst_n) begin
            for (int l = 0; l < LN; l++) begin
                mq[l].delete();
                m_started[l] = 0;
            end
            m_rel = 0; m_ovf = 0; m_depth = 32;
        end else begin
            if (relink) begin
                for (int l = 0; l < LN; l++) begin
                    mq[l].delete();
                    m_started[l] = 0;
                end
                m_rel = 0; m_ovf = 0;
            end else begin
                all_in = 1; any_en = 0;
                for (int l = 0; l < LN; l++) begin
                    if (lane_enable[l]) begin
                        any_en = 1;
                        if (!m_started[l]) all_in = 0;
                    end
                end
                tgt = auto_release ? (int'(last_arrival) + 4) % PER : int'(release_at);
                was_rel = m_rel;
                for (int l = 0; l < LN; l++) begin
                    if (!lane_enable[l]) begin
                        mq[l].delete();
                        m_started[l] = 0;
                    end else if (m_started[l]) begin
                        if (!was_rel && mq[l].size() >= m_depth) begin
                            m_ovf = 1;
                        end else begin
                            if (was_rel) void'(mq[l].pop_front());
                            mq[l].push_back(lane_data[l*DW +: DW]);
                        end
                    end else if (lane_marker[l]) begin
                        m_started[l] = 1;
                        mq[l].push_back(lane_data[l*DW +: DW]);
                    end
                end
                if (!was_rel && all_in && any_en && int'(mb_count) == tgt) m_rel = 1;
            end
            if (depth_wr) m_depth = int'(depth_m1) + 1;
        end
    end

    bit               seen_valid = 0;
    int               first_mc = -1;
    int               first_tick = -1;
    int               tick_n = 0;
    logic [LN*DW-1:0] first_words = '0;

    always @(negedge clk) begin : compare
        bit            exp_v;
        logic [DW-1:0] exp_w;
        if (rst_n) begin
            exp_v = m_rel && !m_ovf;
            check(aligned_valid == exp_v, cur_tag, "aligned_valid", int'(aligned_valid), int'(exp_v));
            check(overflow_err == m_ovf, cur_tag, "overflow_err", int'(overflow_err), int'(m_ovf));
            if (exp_v) begin
                for (int l = 0; l < LN; l++) begin
                    exp_w = (!lane_enable[l] || mq[l].size() == 0) ? '0 : mq[l][0];
                    check(aligned_data[l*DW +: DW] == exp_w, "R7", "lane word",
                          int'(aligned_data[l*DW +: DW]), int'(exp_w));
                end
            end
            if (aligned_valid && !seen_valid) begin
                seen_valid  = 1;
                first_mc    = int'(mb_count);
                first_tick  = tick_n;
                first_words = aligned_data;
            end
        end
    end

    int            start_at [LN];
    bit [LN-1:0]   marked;
    logic [DW-1:0] marker_word [LN];
    int            seq = 0;
    int            jump_from = -1;
    int            jump_to = 0;

    task automatic tick();
        @(negedge clk); #1;
        if (jump_from >= 0 && int'(mb_count) == jump_from && (&marked))
            mb_count = CW'(jump_to - 1);
        mb_count = CW'((int'(mb_count) + 1) % PER);
        seq++;
        for (int l = 0; l < LN; l++) begin
            lane_data[l*DW +: DW] = DW'(seq * 7 + l * 40 + 1);
            lane_marker[l] = !marked[l] && (int'(mb_count) == start_at[l]);
            if (lane_marker[l]) begin
                marked[l] = 1;
                marker_word[l] = lane_data[l*DW +: DW];
            end
        end
        tick_n++;
    endtask

    task automatic scenario(input string tag, input int s0, input int s1, input int s2, input int s3,
                            input logic [LN-1:0] en, input int rbd, input bit aut, input int last,
                            input int mc0, input int n);
        @(negedge clk); #1;
        cur_tag = tag;
        relink = 1'b1;
        lane_marker = '0;
        lane_enable = en;
        release_at = CW'(rbd);
        auto_release = aut;
        last_arrival = CW'(last);
        mb_count = CW'(mc0);
        start_at[0] = s0; start_at[1] = s1; start_at[2] = s2; start_at[3] = s3;
        marked = '0;
        seen_valid = 0;
        tick_n = 0;
        @(negedge clk);
        // R10: state cleared in the cycle after relink
        check(!overflow_err && !aligned_valid, "R10", "clear after relink",
              int'(overflow_err) + int'(aligned_valid), 0);
        #1 relink = 1'b0;
        repeat (n) tick();
    endtask

    task automatic load_depth(input int v);
        @(negedge clk); #1;
        depth_wr = 1'b1;
        depth_m1 = DCW'(v);
        @(negedge clk); #1;
        depth_wr = 1'b0;
    endtask

    initial begin : watchdog
        #1600000;
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(!aligned_valid && !overflow_err, "R2", "reset outputs",
              int'(aligned_valid) + int'(overflow_err), 0);
        #1 rst_n = 1'b1;

        // R2: default depth 32 just fits a 31-word lead
        scenario("R2", 0, 10, 20, 30, 4'hF, 31, 0, 0, 63, 45);
        check(seen_valid, "R2", "released at default depth", int'(seen_valid), 1);
        check(first_mc == 31, "R2", "release count", first_mc, 31);
        // R2: one word more overflows
        scenario("R2", 0, 10, 20, 30, 4'hF, 32, 0, 0, 63, 45);
        check(overflow_err, "R2", "overflow at depth 32", int'(overflow_err), 1);

        // R3, R5, R7: manual release at count 10
        scenario("R3", 3, 4, 5, 6, 4'hF, 10, 0, 0, 0, 30);
        check(first_mc == 10, "R3", "release count", first_mc, 10);
        for (int l = 0; l < LN; l++)
            check(first_words[l*DW +: DW] == marker_word[l], "R5", "first word is marker word",
                  int'(first_words[l*DW +: DW]), int'(marker_word[l]));

        // R8: early match ignored, counter jumped back for a second match
        jump_from = 21; jump_to = 8;
        scenario("R8", 3, 4, 5, 20, 4'hF, 10, 0, 0, 0, 35);
        jump_from = -1;
        check(first_tick == 24, "R8", "release on second match", first_tick, 24);
        check(first_mc == 10, "R8", "release count", first_mc, 10);

        // R4: automatic release point
        scenario("R4", 1, 2, 4, 6, 4'hF, 50, 1, 6, 0, 30);
        check(first_mc == 10, "R4", "auto 6+4", first_mc, 10);
        scenario("R4", 58, 59, 60, 62, 4'hF, 0, 1, 62, 50, 30);
        check(first_mc == 2, "R4", "auto wrap 62+4", first_mc, 2);

        // R1, R6: depth 7 overflows with a 7-word lead
        load_depth(6);
        scenario("R1", 3, 4, 5, 9, 4'hF, 10, 0, 0, 0, 30);
        check(overflow_err, "R1", "overflow at depth 7", int'(overflow_err), 1);
        check(!seen_valid, "R6", "no valid after overflow", int'(seen_valid), 0);
        // R1: depth 8 holds the same lead
        load_depth(7);
        scenario("R1", 3, 4, 5, 9, 4'hF, 10, 0, 0, 0, 30);
        check(!overflow_err && seen_valid, "R1", "depth 8 fits", int'(overflow_err), 0);

        // R9: lane 2 disabled
        load_depth(31);
        scenario("R9", 3, 4, -1, 6, 4'b1011, 10, 0, 0, 0, 25);
        check(seen_valid, "R9", "release without disabled lane", int'(seen_valid), 1);
        check(first_words[2*DW +: DW] == '0, "R9", "disabled lane reads zero",
              int'(first_words[2*DW +: DW]), 0);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule